// File: doc/BRIEF.md
# Scaled-Increment Platform Timebase Counter

This block keeps a free-running 64-bit time value in which one count always means 10 ns, so software sees a 100 MHz timebase. The clock that drives it may run anywhere from 10 MHz to 100 MHz. When that clock is slower than 100 MHz, every edge adds a step larger than one, so the value stays in 10 ns units. The step is either taken from an input port, so it can be set at run time, or fixed by a parameter.

Software can overwrite the whole value through a load port. A narrow 32-bit bus reads the value as two words. Reading the low word snapshots the upper half into a shadow register. A later read of the high word returns that snapshot, so a carry between the two reads cannot give a torn value.

Top module: `timebase_counter`

## Requirements
- R1: A synchronous active-high reset sets the time value, the wrap flag and the high-word shadow to zero.
- R2: On each clock edge without reset or load, the time value grows by the effective step, which is a value from 1 to 10.
- R3: A requested step of 0 or greater than 10 is replaced by a step of 1, whether it comes from the port or from the parameter.
- R4: When the load strobe is high at an edge, the time value becomes exactly the load value and no step is added at that edge. Reset takes priority over load.
- R5: The addition wraps modulo 2^64. The wrap flag is high for exactly the one cycle after an edge whose addition carried out of bit 63, and it is low after a load.
- R6: Apart from loads and wraps, every update makes the time value strictly larger than it was before.
- R7: With the word select low (0 = low word), the read data is bits 31:0 of the live time value. If the read strobe is also high, the edge that ends that cycle stores bits 63:32 of the value in the shadow.
- R8: With the word select high (1 = high word), the read data is the shadow, not the live upper word.
- R9: When the parameter STEP_FROM_PORT is 0, the step comes from the parameter FIXED_STEP (after the R3 clamp), and the step input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, 10 MHz to 100 MHz |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 4 | Requested increment per edge, in 10 ns units |
| load_en_i | input | 1 | Load strobe: replaces the value at the next edge |
| load_val_i | input | 64 | Value to load |
| rd_en_i | input | 1 | Read strobe: a low-word read captures the shadow |
| rd_hi_i | input | 1 | Word select: 0 = low word, 1 = high word (shadow) |
| rd_data_o | output | 32 | Read word |
| time_o | output | 64 | Live time value |
| wrap_o | output | 1 | One-cycle flag after a carry out of bit 63 |

## Verification
The bench builds two instances. The first takes its step from the port and runs with steps of 1, 4 and 10, plus the out-of-range requests 0 and 15. This reaches the exact N-times-step totals, the clamp, loads, a wrap near 2^64, and a low/high read pair that straddles a carry into bit 32. The second instance is built with STEP_FROM_PORT at 0 and FIXED_STEP at 4, while its step input sees the same changing values as the first. This shows that the fixed-step variant ignores the port.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int CNT_W    = 64;
    localparam int BUS_W    = 32;
    localparam int STEP_W   = 4;
    localparam int STEP_MAX = 10;

    typedef logic [CNT_W-1:0]  tval_t;
    typedef logic [STEP_W-1:0] step_t;
    typedef logic [BUS_W-1:0]  word_t;

    typedef struct packed {
        tval_t value;
        logic  wrap;
    } tstate_t;

    typedef struct packed {
        logic  carry;
        tval_t sum;
    } tsum_t;

    // Out-of-range steps collapse to one unit per edge.
    function automatic step_t clamp_step(input step_t req, input int max_step);
        if (req == '0 || int'(req) > max_step)
            return step_t'(1);
        return req;
    endfunction

endpackage

// File: rtl/tbase_step_sel.sv
module tbase_step_sel
    import tbase_pkg::*;
#(
    parameter bit STEP_FROM_PORT = 1'b1,
    parameter int FIXED_STEP     = 1,
    parameter int MAX_STEP       = STEP_MAX
) (
    input  step_t step_i,
    output step_t step_o
);
    generate
        if (STEP_FROM_PORT) begin : g_port
            assign step_o = clamp_step(step_i, MAX_STEP);
        end else begin : g_fixed
            localparam step_t FIX_RAW = step_t'(FIXED_STEP);
            localparam step_t FIX_EFF = (FIXED_STEP <= 0 || FIXED_STEP > MAX_STEP)
                                        ? step_t'(1) : FIX_RAW;
            assign step_o = FIX_EFF;
        end
    endgenerate
endmodule

// File: rtl/tbase_adder.sv
module tbase_adder
    import tbase_pkg::*;
(
    input  tval_t base_i,
    input  step_t step_i,
    output tsum_t res_o
);
    localparam int PAD_W = CNT_W - STEP_W;

    always_comb begin
        res_o = {1'b0, base_i} + {1'b0, {PAD_W{1'b0}}, step_i};
    end
endmodule

// File: rtl/tbase_read_port.sv
module tbase_read_port
    import tbase_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en_i,
    input  logic  rd_hi_i,
    input  tval_t value_i,
    output word_t rd_data_o
);
    localparam int HI_LSB = CNT_W - BUS_W;

    word_t shadow_q;

    always_ff @(posedge clk) begin
        if (rst)
            shadow_q <= '0;
        else if (rd_en_i && !rd_hi_i)
            shadow_q <= value_i[CNT_W-1:HI_LSB];
    end

    assign rd_data_o = rd_hi_i ? shadow_q : value_i[BUS_W-1:0];
endmodule

// File: rtl/timebase_counter.sv
module timebase_counter
    import tbase_pkg::*;
#(
    parameter bit STEP_FROM_PORT = 1'b1,
    parameter int FIXED_STEP     = 1,
    parameter int MAX_STEP       = STEP_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STEP_W-1:0] step_i,
    input  logic              load_en_i,
    input  logic [CNT_W-1:0]  load_val_i,
    input  logic              rd_en_i,
    input  logic              rd_hi_i,
    output logic [BUS_W-1:0]  rd_data_o,
    output logic [CNT_W-1:0]  time_o,
    output logic              wrap_o
);
    step_t   step_eff;
    tsum_t   add_res;
    tstate_t st_q;

    tbase_step_sel #(
        .STEP_FROM_PORT (STEP_FROM_PORT),
        .FIXED_STEP     (FIXED_STEP),
        .MAX_STEP       (MAX_STEP)
    ) u_step (
        .step_i (step_i),
        .step_o (step_eff)
    );

    tbase_adder u_add (
        .base_i (st_q.value),
        .step_i (step_eff),
        .res_o  (add_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (load_en_i) begin
            st_q.value <= load_val_i;
            st_q.wrap  <= 1'b0;
        end else begin
            st_q.value <= add_res.sum;
            st_q.wrap  <= add_res.carry;
        end
    end

    tbase_read_port u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en_i   (rd_en_i),
        .rd_hi_i   (rd_hi_i),
        .value_i   (st_q.value),
        .rd_data_o (rd_data_o)
    );

    assign time_o = st_q.value;
    assign wrap_o = st_q.wrap;
endmodule

// File: rtl/tbase_checker.sv
module tbase_checker
    import tbase_pkg::*;
#(
    parameter int MAX_STEP = STEP_MAX
) (
    input logic             clk,
    input logic             rst,
    input logic             load_en_i,
    input logic [CNT_W-1:0] load_val_i,
    input logic             rd_en_i,
    input logic             rd_hi_i,
    input logic [BUS_W-1:0] rd_data_o,
    input logic [CNT_W-1:0] time_o,
    input logic             wrap_o
);
    localparam tval_t MAX_T = tval_t'(MAX_STEP);

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        !load_en_i |=> ((time_o - $past(time_o)) >= tval_t'(1)) && ((time_o - $past(time_o)) <= MAX_T)); // R2

    AST_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        !load_en_i |=> (time_o > $past(time_o)) || wrap_o); // R6

    AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (rst)
        load_en_i |=> (time_o == $past(load_val_i)) && !wrap_o); // R4

    AST_WRAP_SMALL: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> time_o < MAX_T); // R5

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !rd_hi_i) |=> (rd_hi_i -> rd_data_o == $past(time_o[CNT_W-1:CNT_W-BUS_W]))); // R8

endmodule

bind timebase_counter tbase_checker #(.MAX_STEP(MAX_STEP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_en_i  (load_en_i),
    .load_val_i (load_val_i),
    .rd_en_i    (rd_en_i),
    .rd_hi_i    (rd_hi_i),
    .rd_data_o  (rd_data_o),
    .time_o     (time_o),
    .wrap_o     (wrap_o)
);

// File: tb/sim_timebase_counter.sv
`timescale 1ns/1ps
module sim_timebase_counter;
    import tbase_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    step_t       step = step_t'(1);
    logic        load_en = 1'b0;
    tval_t       load_val = '0;
    logic        rd_en = 1'b0;
    logic        rd_hi = 1'b0;
    word_t       rd_data, rd_data1;
    tval_t       tm, tm1;
    logic        wrap, wrap1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    timebase_counter u0 (
        .clk(clk), .rst(rst), .step_i(step), .load_en_i(load_en),
        .load_val_i(load_val), .rd_en_i(rd_en), .rd_hi_i(rd_hi),
        .rd_data_o(rd_data), .time_o(tm), .wrap_o(wrap)
    );

    timebase_counter #(.STEP_FROM_PORT(1'b0), .FIXED_STEP(4)) u1 (
        .clk(clk), .rst(rst), .step_i(step), .load_en_i(1'b0),
        .load_val_i('0), .rd_en_i(1'b0), .rd_hi_i(1'b0),
        .rd_data_o(rd_data1), .time_o(tm1), .wrap_o(wrap1)
    );

    task automatic chk(input string req, input tval_t act, input tval_t exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; load_en = 1'b0; rd_en = 1'b0; rd_hi = 1'b0;
        @(negedge clk);
        chk("R1 time", tm, '0);
        chk("R1 wrap", tval_t'(wrap), '0);
        chk("R1 shadow", tval_t'(u0.rd_data_o & {BUS_W{rd_hi}}), '0);
        rst = 1'b0;
    endtask

    // Run n edges with requested step s; expect n*eff and strict growth.
    task automatic run_step(input step_t s, input int n, input tval_t eff, input string req);
        tval_t prev;
        do_reset();
        step = s;
        prev = tm;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            checks++;
            if (!(tm > prev)) begin
                errors++;
                $display("FAIL R6 actual=%h expected>%h", tm, prev);
            end
            prev = tm;
        end
        chk(req, tm, tval_t'(n) * eff);
        chk("R9 fixed step ignores port", tm1, tval_t'(n) * tval_t'(4));
    endtask

    task automatic t_load();
        do_reset();
        step = step_t'(4);
        repeat (3) @(negedge clk);
        load_en = 1'b1; load_val = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        chk("R4 load exact, no step", tm, 64'h1234_5678_9ABC_DEF0);
        load_en = 1'b0;
        @(negedge clk);
        chk("R2 step after load", tm, 64'h1234_5678_9ABC_DEF4);
        rst = 1'b1; load_en = 1'b1;
        @(negedge clk);
        chk("R4 reset beats load", tm, '0);
        rst = 1'b0; load_en = 1'b0;
    endtask

    task automatic t_wrap();
        do_reset();
        step = step_t'(4);
        load_en = 1'b1; load_val = 64'hFFFF_FFFF_FFFF_FFFD;
        @(negedge clk);
        chk("R5 no wrap flag on load", tval_t'(wrap), '0);
        load_en = 1'b0;
        @(negedge clk);
        chk("R5 wrapped value", tm, 64'd1);
        chk("R5 wrap flag high", tval_t'(wrap), 64'd1);
        @(negedge clk);
        chk("R5 wrap flag one cycle", tval_t'(wrap), '0);
        chk("R5 value after wrap", tm, 64'd5);
    endtask

    task automatic t_read();
        do_reset();
        step = step_t'(4);
        load_en = 1'b1; load_val = 64'h0000_0007_FFFF_FFFE;
        @(negedge clk);
        load_en = 1'b0;
        rd_en = 1'b1; rd_hi = 1'b0;
        #0.1;
        chk("R7 low word", tval_t'(rd_data), 64'h0000_0000_FFFF_FFFE);
        @(negedge clk);
        rd_en = 1'b0; rd_hi = 1'b1;
        #0.1;
        chk("R8 high word from shadow", tval_t'(rd_data), 64'd7);
        chk("R8 live upper word moved on", tval_t'(tm[63:32]), 64'd8);
        @(negedge clk);
        chk("R8 shadow held without low read", tval_t'(rd_data), 64'd7);
        rd_hi = 1'b0;
    endtask

    initial begin
        run_step(step_t'(1),  40, 64'd1,  "R2 step 1");
        run_step(step_t'(4),  40, 64'd4,  "R2 step 4");
        run_step(step_t'(10), 40, 64'd10, "R2 step 10");
        run_step(step_t'(0),  20, 64'd1,  "R3 step 0 clamps to 1");
        run_step(step_t'(15), 20, 64'd1,  "R3 step 15 clamps to 1");
        run_step(step_t'(11), 20, 64'd1,  "R3 step 11 clamps to 1");
        t_load();
        t_wrap();
        t_read();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule